// File: doc/BRIEF.md
# Single-Bus Microstep Control Sequencer

This block is the hardwired control unit of a processor whose registers, ALU and memory interface all share one internal bus. It walks a fixed list of control steps for the register-plus-memory-indirect add (R1 gets R1 plus the memory word that R3 points at). A step counter is decoded together with the decoded opcode into a one-hot gating vector. That vector enables register drivers and latches, starts memory reads and picks the ALU function. The instruction fetch reuses the ALU to advance the program counter. It clears Y, sets the carry-in and adds, so Z receives PC+1 while memory is being read.

The sequencer is idle after reset and begins a run on the first clock edge that sees `start` high. Two steps wait for the memory-function-complete flag. In those steps the counter holds and the step's gates stay on until the flag is seen high. Every other step lasts one cycle whatever the flag does. The last step raises the end strobe and returns the counter to step 1. In the following cycle `done` is high for one cycle and all gates are low.

Top module: `mstep_seq`

## Requirements
- R1: While reset is asserted and afterwards, until a clock edge samples `start` high, `ctrlGates` is all zero and `done` is 0.
- R2: In the cycle after the edge that samples `start` high while idle, step 1 is active. `ctrlGates` equals 0x007F: pcOut bit0, marIn bit1, memRead bit2, clrY bit3, carryIn bit4, aluAdd bit5 and zIn bit6.
- R3: Step 2 drives zOut bit7 and pcIn bit8, which is 0x0180. It is held, with its gates unchanged, on every edge where `memDone` is 0. It advances on the first edge where `memDone` is 1.
- R4: Step 3 drives mdrOut bit9 and irIn bit10, which is 0x0600.
- R5: When `opcode` equals ADD_OP (default 3) in step 4, step 4 drives r3Out bit11, marIn bit1 and memRead bit2, which is 0x0806.
- R6: Step 5 drives r1Out bit12 and yIn bit13, which is 0x3000. It waits for `memDone` in the same way as step 2.
- R7: Step 6 drives mdrOut, aluAdd and zIn, which is 0x0260. Step 7 drives zOut, r1In bit14 and endStep bit15, which is 0xC080.
- R8: `done` is high for exactly the one cycle after the end-strobe cycle. In that cycle `ctrlGates` is zero and the counter is back at step 1.
- R9: `start` has no effect while a run is in progress. The step sequence and its timing are unchanged.
- R10: When `opcode` is not ADD_OP in step 4, step 4 drives endStep only (0x8000). The run then ends as in R8.
- R11: At most one bus driver among pcOut, zOut, mdrOut, r3Out and r1Out is high in any cycle.
- R12: `memDone` has no effect outside steps 2 and 5. Every other step lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when idle |
| opcode | input | OP_W | Decoded opcode of the fetched instruction |
| memDone | input | 1 | Memory function complete |
| ctrlGates | output | 16 | One-hot gating signal vector |
| done | output | 1 | One-cycle pulse after the end step |

## Verification
The assertions check on every cycle that no two bus drivers are on together. They also check that a waiting memory step keeps its gates while the flag is low. Finally they check that `done` lasts one cycle, follows an end strobe and comes with zero gates. Only the bench scenarios can show that the vector for each step is correct, and that the fetch happens before the opcode-dependent steps. The same holds for a held `start` being ignored mid-run, for long and zero-length memory waits, and for the early end on a foreign opcode. The bench shows these by comparing against a behavioural step model on every clock.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  localparam int GATE_W = 16;
  localparam int G_PCOUT   = 0;
  localparam int G_MARIN   = 1;
  localparam int G_READ    = 2;
  localparam int G_CLRY    = 3;
  localparam int G_CARRY   = 4;
  localparam int G_ADD     = 5;
  localparam int G_ZIN     = 6;
  localparam int G_ZOUT    = 7;
  localparam int G_PCIN    = 8;
  localparam int G_MDROUT  = 9;
  localparam int G_IRIN    = 10;
  localparam int G_R3OUT   = 11;
  localparam int G_R1OUT   = 12;
  localparam int G_YIN     = 13;
  localparam int G_R1IN    = 14;
  localparam int G_END     = 15;

  typedef struct packed {
    logic launch;
    logic advance;
    logic restart;
  } stepCmd_t;
endpackage

// File: rtl/mstep_counter.sv
module mstep_counter
  import mstep_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  stepCmd_t          cmd,
  output logic [STEP_W-1:0] step,
  output logic              running,
  output logic              done
);
  localparam logic [STEP_W-1:0] FIRST_STEP = STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= FIRST_STEP;
      running <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= cmd.restart;
      if (cmd.restart) begin
        step    <= FIRST_STEP;
        running <= 1'b0;
      end else if (cmd.launch) begin
        running <= 1'b1;
      end else if (cmd.advance) begin
        step <= step + STEP_W'(1);
      end
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_back_to_first: assert property (@(posedge clk) disable iff (rst)
    done |-> (step == FIRST_STEP && !running));
endmodule

// File: rtl/mstep_decode.sv
module mstep_decode
  import mstep_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int OP_W   = 4,
  parameter logic [OP_W-1:0] ADD_OP = OP_W'(3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  input  logic              running,
  input  logic              start,
  input  logic              memDone,
  input  logic [OP_W-1:0]   opcode,
  output logic [GATE_W-1:0] gates,
  output stepCmd_t          cmd
);
  logic             isAdd;
  logic             waitStep;
  logic [GATE_W-1:0] raw;
  logic [4:0]       busOuts;

  assign isAdd = (opcode == ADD_OP);

  always_comb begin
    raw      = '0;
    waitStep = 1'b0;
    case (step)
      STEP_W'(1): begin
        raw[G_PCOUT] = 1'b1; raw[G_MARIN] = 1'b1; raw[G_READ] = 1'b1;
        raw[G_CLRY]  = 1'b1; raw[G_CARRY] = 1'b1; raw[G_ADD]  = 1'b1;
        raw[G_ZIN]   = 1'b1;
      end
      STEP_W'(2): begin
        raw[G_ZOUT] = 1'b1; raw[G_PCIN] = 1'b1;
        waitStep    = 1'b1;
      end
      STEP_W'(3): begin
        raw[G_MDROUT] = 1'b1; raw[G_IRIN] = 1'b1;
      end
      STEP_W'(4): begin
        if (isAdd) begin
          raw[G_R3OUT] = 1'b1; raw[G_MARIN] = 1'b1; raw[G_READ] = 1'b1;
        end else begin
          raw[G_END] = 1'b1;
        end
      end
      STEP_W'(5): begin
        raw[G_R1OUT] = 1'b1; raw[G_YIN] = 1'b1;
        waitStep     = 1'b1;
      end
      STEP_W'(6): begin
        raw[G_MDROUT] = 1'b1; raw[G_ADD] = 1'b1; raw[G_ZIN] = 1'b1;
      end
      STEP_W'(7): begin
        raw[G_ZOUT] = 1'b1; raw[G_R1IN] = 1'b1; raw[G_END] = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  assign gates       = running ? raw : '0;
  assign cmd.launch  = !running && start;
  assign cmd.restart = running && raw[G_END];
  assign cmd.advance = running && !raw[G_END] && !(waitStep && !memDone);

  assign busOuts = {gates[G_PCOUT], gates[G_ZOUT], gates[G_MDROUT],
                    gates[G_R3OUT], gates[G_R1OUT]};

  a_r11_single_bus_driver: assert property (@(posedge clk) disable iff (rst)
    $countones(busOuts) <= 1);
endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
  import mstep_pkg::*;
#(
  parameter int NUM_STEPS = 7,
  parameter int OP_W      = 4,
  parameter logic [OP_W-1:0] ADD_OP = OP_W'(3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic              memDone,
  output logic [GATE_W-1:0] ctrlGates,
  output logic              done
);
  localparam int STEP_W = $clog2(NUM_STEPS + 1);

  logic [STEP_W-1:0] step;
  logic              running;
  stepCmd_t          cmd;

  mstep_counter #(.STEP_W(STEP_W)) u_counter (
    .clk(clk), .rst(rst), .cmd(cmd),
    .step(step), .running(running), .done(done)
  );

  mstep_decode #(.STEP_W(STEP_W), .OP_W(OP_W), .ADD_OP(ADD_OP)) u_decode (
    .clk(clk), .rst(rst), .step(step), .running(running),
    .start(start), .memDone(memDone), .opcode(opcode),
    .gates(ctrlGates), .cmd(cmd)
  );

  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    ((ctrlGates[G_PCIN] || ctrlGates[G_YIN]) && !memDone) |=> $stable(ctrlGates));
  a_r8_done_after_end: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ctrlGates[G_END]));
  a_r8_quiet_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctrlGates == '0));
endmodule

// File: tb/mstep_seq_bench.sv
module mstep_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  opcode = 4'd3;
  logic        memDone = 1'b0;
  logic [15:0] ctrlGates;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int mStep = 1;
  bit mRun = 1'b0;
  bit mDone = 1'b0;

  always #4 clk = ~clk;

  mstep_seq u_mstep_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .memDone(memDone), .ctrlGates(ctrlGates), .done(done)
  );

  function automatic logic [15:0] expVec(int s, logic [3:0] op, bit run);
    if (!run) return 16'h0000;
    case (s)
      1: return 16'h007F;
      2: return 16'h0180;
      3: return 16'h0600;
      4: return (op == 4'd3) ? 16'h0806 : 16'h8000;
      5: return 16'h3000;
      6: return 16'h0260;
      7: return 16'hC080;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tagFor(int s, bit run, bit dn, bit st, bit md, logic [3:0] op);
    if (dn) return "R8";
    if (!run) return "R1";
    if (st) return "R9";
    if (!md && s != 2 && s != 5) return "R12";
    case (s)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return (op == 4'd3) ? "R5" : "R10";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      mStep <= 1; mRun <= 1'b0; mDone <= 1'b0;
    end else begin
      logic [15:0] v;
      v = expVec(mStep, opcode, mRun);
      mDone <= 1'b0;
      if (!mRun) begin
        if (start) mRun <= 1'b1;
      end else if (v[15]) begin
        mRun <= 1'b0; mStep <= 1; mDone <= 1'b1;
      end else if ((mStep == 2 || mStep == 5) && !memDone) begin
        mStep <= mStep;
      end else begin
        mStep <= mStep + 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [15:0] ev;
    string tg;
    int nb;
    ev = expVec(mStep, opcode, mRun);
    tg = tagFor(mStep, mRun, mDone, start, memDone, opcode);
    checks++;
    if (ctrlGates !== ev) begin
      failures++;
      $display("FAIL %s gates actual=%h expected=%h", tg, ctrlGates, ev);
    end
    checks++;
    if (done !== mDone) begin
      failures++;
      $display("FAIL %s done actual=%b expected=%b", tg, done, mDone);
    end
    nb = int'(ctrlGates[0]) + int'(ctrlGates[7]) + int'(ctrlGates[9]) +
         int'(ctrlGates[11]) + int'(ctrlGates[12]);
    checks++;
    if (nb > 1) begin
      failures++;
      $display("FAIL R11 bus drivers actual=%0d expected<=1", nb);
    end
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic waitDone();
    int guard;
    guard = 0;
    while (!mDone && guard < 200) begin
      tick(1);
      guard++;
    end
    tick(1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(4);
    // R2..R8: plain add, memory completes at once
    memDone = 1'b1; opcode = 4'd3;
    start = 1'b1; tick(1); start = 1'b0;
    waitDone();
    // R3, R6, R12: flag low except a pulse in each wait step
    memDone = 1'b0;
    start = 1'b1; tick(1); start = 1'b0;
    tick(1);            // step 1, flag low, no stall (R12)
    tick(3);            // step 2 held three edges (R3)
    memDone = 1'b1; tick(1); memDone = 1'b0;
    tick(2);            // steps 3 and 4 with flag low
    tick(4);            // step 5 held (R6)
    memDone = 1'b1; tick(1); memDone = 1'b0;
    waitDone();
    // R9: start held high through the run
    memDone = 1'b1;
    start = 1'b1; tick(6);
    start = 1'b0;
    waitDone();
    // R10: foreign opcode ends early
    opcode = 4'd9;
    start = 1'b1; tick(1); start = 1'b0;
    waitDone();
    opcode = 4'd3;
    tick(5);
    // R1: reset mid run returns to quiet
    start = 1'b1; tick(1); start = 1'b0; tick(2);
    rst = 1'b1; tick(2); rst = 1'b0;
    tick(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule